// File: doc/BRIEF.md
# Signed-Count Word Shifter and Logic Unit

This block is a single-issue execution unit for 16-bit accumulator words. Each cycle it may accept one operation made of an opcode and two operands, A and B. One clock later it presents the result in a register, together with a valid strobe. An error flag accompanies the result when the opcode is not one the block implements.

The unit covers four kinds of work. It has fixed right shifts of one to six places and fixed left shifts of one to seven places. It has two shifts whose count is taken from B as a signed two's-complement number, where a negative count turns the shift the other way and any magnitude of the word width or more gives zero. It also has three bitwise combinations of A and B: OR, exclusive OR and equivalence. Every shift is logical and fills vacated positions with zeros. A surrounding datapath issues an operation with `in_valid` and collects `res` when `res_valid` is high.

Top module: `acc_shift_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res`, `res_valid` and `op_err` are all cleared to zero on that edge (synchronous reset).
- R2: Opcodes 5'h00 to 5'h05 shift A right by (op[2:0] + 1) places, that is by 1 to 6, and fill from the left with zeros.
- R3: Opcodes 5'h08 to 5'h0E shift A left by (op[2:0] + 1) places, that is by 1 to 7, and fill from the right with zeros.
- R4: Opcode 5'h10 (variable left) reads B as a signed 16-bit count. A count of zero or more shifts A left by B. A negative count shifts A right by -B.
- R5: Opcode 5'h11 (variable right) reads B as a signed 16-bit count. A count of zero or more shifts A right by B. A negative count shifts A left by -B.
- R6: For opcodes 5'h10 and 5'h11, when the magnitude of B is 16 or greater (this includes B = 16'h8000), the result is all zeros.
- R7: For opcodes 5'h10 and 5'h11, a count B of zero returns A unchanged.
- R8: Opcode 5'h12 returns A OR B. Opcode 5'h13 returns A XOR B. Opcode 5'h14 returns A XOR (NOT B).
- R9: When `in_valid` is high at a rising edge, `res_valid` is high during the following cycle. When `in_valid` is low at a rising edge, `res_valid` is low during the following cycle.
- R10: Any other opcode (5'h06, 5'h07, 5'h0F, 5'h15 to 5'h1F) returns A unchanged and raises `op_err` for that one result cycle. `op_err` is low after every implemented opcode and in every cycle with no result.
- R11: In a cycle that follows an edge where `in_valid` was low, `res` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code |
| a | input | 16 | Operand A, the word that is shifted or combined |
| b | input | 16 | Operand B, a signed count or a logic operand |
| res | output | 16 | Registered result |
| res_valid | output | 1 | `res` holds a new result this cycle |
| op_err | output | 1 | The result came from an unimplemented opcode |

## Verification
All results, including the error flag, come from a single register stage. Each is therefore due exactly one rising edge after the edge that accepted the operation. The bench changes inputs on the falling edge and samples `res`, `res_valid` and `op_err` on the next falling edge. Each reading then falls halfway through the cycle in which that operation's result must be visible. The bench issues operations back to back, so each sample also confirms that the previous operation has been replaced. Idle checks take place one falling edge after `in_valid` is dropped, which is when the strobe must already be low and the held word must be unchanged.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 5;

    localparam logic [OP_W-1:0] OPC_VAR_LEFT  = 5'h10;
    localparam logic [OP_W-1:0] OPC_VAR_RIGHT = 5'h11;
    localparam logic [OP_W-1:0] OPC_OR        = 5'h12;
    localparam logic [OP_W-1:0] OPC_XOR       = 5'h13;
    localparam logic [OP_W-1:0] OPC_EQV       = 5'h14;

    // Highest op[2:0] value that is legal in each constant-shift group
    localparam logic [2:0] CONST_RIGHT_LAST = 3'd5;
    localparam logic [2:0] CONST_LEFT_LAST  = 3'd6;

    typedef enum logic [2:0] {
        K_SHIFT = 3'd0,
        K_OR    = 3'd1,
        K_XOR   = 3'd2,
        K_EQV   = 3'd3,
        K_PASS  = 3'd4
    } op_kind_e;

endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] b,
    output op_kind_e         kind,
    output logic             shift_left,
    output logic [WIDTH-1:0] count,
    output logic             unsupported
);

    logic [WIDTH-1:0] const_amt;

    always_comb begin
        const_amt   = WIDTH'(op[2:0]) + WIDTH'(1);
        kind        = K_PASS;
        shift_left  = 1'b0;
        count       = '0;
        unsupported = 1'b0;

        unique case (op[4:3])
            2'b00: begin
                if (op[2:0] <= CONST_RIGHT_LAST) begin
                    kind       = K_SHIFT;
                    shift_left = 1'b0;
                    count      = const_amt;
                end else begin
                    unsupported = 1'b1;
                end
            end
            2'b01: begin
                if (op[2:0] <= CONST_LEFT_LAST) begin
                    kind       = K_SHIFT;
                    shift_left = 1'b1;
                    count      = const_amt;
                end else begin
                    unsupported = 1'b1;
                end
            end
            2'b10: begin
                if (op == OPC_VAR_LEFT) begin
                    kind       = K_SHIFT;
                    shift_left = 1'b1;
                    count      = b;
                end else if (op == OPC_VAR_RIGHT) begin
                    kind       = K_SHIFT;
                    shift_left = 1'b0;
                    count      = b;
                end else if (op == OPC_OR) begin
                    kind = K_OR;
                end else if (op == OPC_XOR) begin
                    kind = K_XOR;
                end else if (op == OPC_EQV) begin
                    kind = K_EQV;
                end else begin
                    unsupported = 1'b1;
                end
            end
            default: begin
                unsupported = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/acc_signed_shifter.sv
module acc_signed_shifter #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] count,
    input  logic             shift_left,
    output logic [WIDTH-1:0] shifted
);

    localparam int SH_W = $clog2(WIDTH);
    localparam int MAG_W = WIDTH + 1;

    logic             negative;
    logic             go_left;
    logic [MAG_W-1:0] wide_count;
    logic [MAG_W-1:0] magnitude;
    logic             too_far;
    logic [SH_W-1:0]  amount;

    always_comb begin
        negative   = count[WIDTH-1];
        go_left    = shift_left ^ negative;
        wide_count = {count[WIDTH-1], count};
        magnitude  = negative ? (MAG_W'(0) - wide_count) : wide_count;
        too_far    = magnitude >= MAG_W'(WIDTH);
        amount     = magnitude[SH_W-1:0];

        if (too_far) begin
            shifted = '0;
        end else if (go_left) begin
            shifted = data << amount;
        end else begin
            shifted = data >> amount;
        end
    end

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  op_kind_e         kind,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    logic [WIDTH-1:0] b_eff;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            always_comb begin
                b_eff[gi] = (kind == K_EQV) ? ~b[gi] : b[gi];
                if (kind == K_OR) begin
                    y[gi] = a[gi] | b_eff[gi];
                end else begin
                    y[gi] = a[gi] ^ b_eff[gi];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/acc_shift_alu.sv
module acc_shift_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             res_valid,
    output logic             op_err
);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             vld;
        logic             err;
    } out_state_t;

    out_state_t state_d;
    out_state_t state_q;

    op_kind_e         kind;
    logic             dec_left;
    logic [WIDTH-1:0] dec_count;
    logic             dec_bad;
    logic [WIDTH-1:0] shift_y;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] result_d;

    acc_op_decode #(.WIDTH(WIDTH)) u_decode (
        .op          (op),
        .b           (b),
        .kind        (kind),
        .shift_left  (dec_left),
        .count       (dec_count),
        .unsupported (dec_bad)
    );

    acc_signed_shifter #(.WIDTH(WIDTH)) u_shift (
        .data       (a),
        .count      (dec_count),
        .shift_left (dec_left),
        .shifted    (shift_y)
    );

    acc_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .kind (kind),
        .a    (a),
        .b    (b),
        .y    (logic_y)
    );

    always_comb begin
        unique case (kind)
            K_SHIFT:             result_d = shift_y;
            K_OR, K_XOR, K_EQV:  result_d = logic_y;
            default:             result_d = a;
        endcase

        state_d     = state_q;
        state_d.vld = in_valid;
        state_d.err = 1'b0;
        if (in_valid) begin
            state_d.res = result_d;
            state_d.err = dec_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res       = state_q.res;
    assign res_valid = state_q.vld;
    assign op_err    = state_q.err;

endmodule

// File: rtl/acc_shift_alu_chk.sv
module acc_shift_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [4:0]       op,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [WIDTH-1:0] res,
    input logic             res_valid,
    input logic             op_err
);

    logic implemented;
    logic var_op;
    logic big_count;

    always_comb begin
        implemented = (op <= 5'h05) || (op >= 5'h08 && op <= 5'h0E) ||
                      (op >= 5'h10 && op <= 5'h14);
        var_op      = (op == 5'h10) || (op == 5'h11);
        big_count   = ($signed(b) >= 16) || ($signed(b) <= -16);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!res_valid && !op_err && res == '0)); // R1
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> res_valid); // R9
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !res_valid); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(res)); // R11
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst) op_err |-> res_valid); // R10
    AST_BAD_OP_PASS: assert property (@(posedge clk) disable iff (rst) (in_valid && !implemented) |=> (op_err && res == $past(a))); // R10
    AST_GOOD_OP_NO_ERR: assert property (@(posedge clk) disable iff (rst) (in_valid && implemented) |=> !op_err); // R10
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst) (in_valid && var_op && b == '0) |=> res == $past(a)); // R7
    AST_BIG_COUNT: assert property (@(posedge clk) disable iff (rst) (in_valid && var_op && big_count) |=> res == '0); // R6

endmodule

bind acc_shift_alu acc_shift_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .res       (res),
    .res_valid (res_valid),
    .op_err    (op_err)
);

// File: tb/acc_shift_alu_tb.sv
module acc_shift_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic        res_valid;
    logic        op_err;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    acc_shift_alu u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .a         (a),
        .b         (b),
        .res       (res),
        .res_valid (res_valid),
        .op_err    (op_err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Arithmetic reference: shifts as multiply/divide by powers of two
    function automatic int unsigned pow2(input int n);
        return 32'd1 << n;
    endfunction

    function automatic logic [15:0] sh_left(input logic [15:0] v, input int n);
        if (n >= 16) return 16'h0000;
        return 16'((int'(v) * pow2(n)) % 65536);
    endfunction

    function automatic logic [15:0] sh_right(input logic [15:0] v, input int n);
        if (n >= 16) return 16'h0000;
        return 16'(int'(v) / pow2(n));
    endfunction

    task automatic model(input logic [4:0] o, input logic [15:0] av, input logic [15:0] bv,
                         output logic [15:0] exp, output logic err, output string tag);
        int s;
        s   = int'($signed(bv));
        err = 1'b0;
        if (o <= 5'h05) begin
            exp = sh_right(av, int'(o) + 1); tag = "R2";
        end else if (o >= 5'h08 && o <= 5'h0E) begin
            exp = sh_left(av, int'(o) - 7); tag = "R3";
        end else if (o == 5'h10) begin
            exp = (s >= 0) ? sh_left(av, s) : sh_right(av, -s); tag = "R4";
        end else if (o == 5'h11) begin
            exp = (s >= 0) ? sh_right(av, s) : sh_left(av, -s); tag = "R5";
        end else if (o == 5'h12) begin
            exp = av | bv; tag = "R8";
        end else if (o == 5'h13) begin
            exp = av ^ bv; tag = "R8";
        end else if (o == 5'h14) begin
            exp = av ^ ~bv; tag = "R8";
        end else begin
            exp = av; err = 1'b1; tag = "R10";
        end
        if (o == 5'h10 || o == 5'h11) begin
            if (s == 0) tag = "R7";
            else if (s >= 16 || s <= -16) tag = "R6";
        end
    endtask

    task automatic apply(input logic [4:0] o, input logic [15:0] av, input logic [15:0] bv);
        logic [15:0] exp;
        logic        err;
        string       tag;
        model(o, av, bv, exp, err, tag);
        op = o; a = av; b = bv; in_valid = 1'b1;
        @(negedge clk);
        check({tag, " result"}, 32'(res), 32'(exp));
        check("R9 valid", 32'(res_valid), 32'd1);
        check("R10 err flag", 32'(op_err), 32'(err));
    endtask

    initial begin : wdog
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] pats [6];
        logic [15:0] held;
        pats[0] = 16'hFFFF; pats[1] = 16'h8001; pats[2] = 16'h1234;
        pats[3] = 16'hA5C3; pats[4] = 16'h0001; pats[5] = 16'h0000;

        rst = 1'b1; in_valid = 1'b1; op = 5'h12; a = 16'hFFFF; b = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R1 reset res", 32'(res), 32'd0);
        check("R1 reset valid", 32'(res_valid), 32'd0);
        check("R1 reset err", 32'(op_err), 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R9 idle valid", 32'(res_valid), 32'd0);

        // Every opcode, several A patterns, signed counts around the edges
        for (int oi = 0; oi < 32; oi++) begin
            for (int ai = 0; ai < 6; ai++) begin
                for (int bi = -20; bi <= 20; bi++) begin
                    apply(5'(oi), pats[ai], 16'(bi));
                end
                apply(5'(oi), pats[ai], 16'h8000);
                apply(5'(oi), pats[ai], 16'h7FFF);
                apply(5'(oi), pats[ai], 16'h5A0F);
            end
        end

        // Hold behaviour after dropping in_valid (R11, R9)
        apply(5'h13, 16'hC0DE, 16'h0F0F);
        held = res;
        in_valid = 1'b0; op = 5'h12; a = 16'h1111; b = 16'h2222;
        @(negedge clk);
        check("R9 no valid when idle", 32'(res_valid), 32'd0);
        check("R11 res held", 32'(res), 32'(held));
        check("R10 err low when idle", 32'(op_err), 32'd0);
        @(negedge clk);
        check("R11 res still held", 32'(res), 32'(held));

        // Error pulse lasts one cycle (R10)
        apply(5'h1F, 16'hBEEF, 16'h0000);
        apply(5'h12, 16'h00F0, 16'h0F00);
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 err after idle", 32'(op_err), 32'd0);

        // Reset mid-stream clears outputs (R1)
        apply(5'h07, 16'h4321, 16'h0000);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset res late", 32'(res), 32'd0);
        check("R1 reset valid late", 32'(res_valid), 32'd0);
        check("R1 reset err late", 32'(op_err), 32'd0);
        rst = 1'b0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule